// File: doc/BRIEF.md
# Decode-Stage Stall Hazard Detector

This block sits in the decode stage of a five-stage in-order pipeline. It resolves read-after-write dependencies purely by stalling. Each cycle it takes the two source register indices of the instruction being decoded, and a flag per source that says whether the instruction really reads that operand. It compares them with the destination index and write enable of the instruction in the execute-stage register and of the instruction in the memory-stage register.

When a real dependency exists, the unit holds the program counter and the fetch/decode register. It also raises a select that clears every control signal of the instruction being handed to execute, so a bubble with no side effects flows down the pipe. The register file is assumed to write in the first half of a cycle and read in the second. The writeback-stage instruction therefore never needs a comparison. A consumer directly behind its producer waits exactly two cycles, one placed a slot further back waits one, and one further back again waits none.

The unit is purely combinational. The stall drops by itself as soon as the producer has left the memory-stage register, and the held instruction then moves on.

Top module: `hazard_stall_unit`

## Requirements
- R1: When a used source index equals the execute-stage destination index, that destination's write enable is 1 and the index is nonzero, then pc_write = 0, ifid_write = 0 and ctl_zero = 1.
- R2: When a used source index equals the memory-stage destination index, that destination's write enable is 1 and the index is nonzero, the same stall outputs as in R1 appear.
- R3: A destination index of 0 never causes a stall, even with its write enable at 1 and a matching used source.
- R4: A destination whose write enable is 0 never causes a stall, whatever its index.
- R5: A source whose use flag is 0 never causes a stall, whatever its index.
- R6: The outputs are always consistent: ifid_write equals pc_write, and ctl_zero equals the inverse of pc_write.
- R7: With no qualifying match, pc_write = 1, ifid_write = 1 and ctl_zero = 0.
- R8: In a pipeline that inserts bubbles from ctl_zero, a consumer directly behind its producer is stalled exactly 2 cycles, one with one instruction between them exactly 1 cycle, and one with two instructions between them 0 cycles.
- R9: Either source field (the first or the second) alone is enough to trigger a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_idx | input | 5 | First source register index of the decoding instruction |
| src_a_used | input | 1 | First source is read by the decoding instruction |
| src_b_idx | input | 5 | Second source register index of the decoding instruction |
| src_b_used | input | 1 | Second source is read by the decoding instruction |
| exq_dst_idx | input | 5 | Destination index held in the execute-stage register |
| exq_dst_wen | input | 1 | Register write enable held in the execute-stage register |
| memq_dst_idx | input | 5 | Destination index held in the memory-stage register |
| memq_dst_wen | input | 1 | Register write enable held in the memory-stage register |
| pc_write | output | 1 | Program counter may advance (0 while stalled) |
| ifid_write | output | 1 | Fetch/decode register may load (0 while stalled) |
| ctl_zero | output | 1 | Clear the control signals of the instruction entering execute |

## Verification
The hardest case to reach from the ports is the stall count of R8. It depends on the detector's output feeding back into the pipeline: the bubble it inserts must later occupy the memory-stage slot so that the stall drops. The bench therefore wraps the unit in a small model of the fetch/decode, execute and memory registers. The model holds or advances on pc_write and loads a bubble on ctl_zero. Instruction streams with zero, one and two independent instructions between producer and consumer are run through it, and the stall cycles are counted. Single-cycle cases for x0, cleared enables, unused sources and each source field are walked from a vector table.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int REG_IDX_W = 5;
  parameter int NUM_SRC   = 2;
  parameter int NUM_SLOT  = 2;

  typedef logic [REG_IDX_W-1:0] reg_idx_t;

  typedef struct packed {
    reg_idx_t idx;
    logic     used;
  } src_fld_t;

  typedef struct packed {
    reg_idx_t dst;
    logic     wen;
  } prod_slot_t;
endpackage

// File: rtl/hzd_match.sv
module hzd_match
  import hzd_pkg::*;
(
  input  src_fld_t   src,
  input  prod_slot_t prod,
  output logic       hit
);
  logic idx_eq;
  logic prod_live;

  always_comb begin
    idx_eq    = (src.idx == prod.dst);
    prod_live = prod.wen && (prod.dst != '0);
    hit       = src.used && prod_live && idx_eq;
  end
endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
(
  input  src_fld_t   srcs  [NUM_SRC],
  input  prod_slot_t slots [NUM_SLOT],
  output logic       hazard
);
  localparam int NUM_PAIR = NUM_SRC * NUM_SLOT;

  logic [NUM_PAIR-1:0] pair_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar p = 0; p < NUM_SLOT; p++) begin : g_slot
      hzd_match u_match (
        .src  (srcs[s]),
        .prod (slots[p]),
        .hit  (pair_hit[s*NUM_SLOT+p])
      );
    end
  end

  always_comb hazard = |pair_hit;

  always_comb begin
    // R3
    if (slots[0].dst == '0 && slots[1].dst == '0)
      zero_dst_chk: assert (!hazard) else $error("hazard from x0 destination");
    // R5
    if (!srcs[0].used && !srcs[1].used)
      unused_src_chk: assert (!hazard) else $error("hazard from unused source");
  end
endmodule

// File: rtl/hzd_ctl.sv
module hzd_ctl (
  input  logic hazard,
  output logic pc_write,
  output logic ifid_write,
  output logic ctl_zero
);
  logic hold;

  always_comb begin
    hold       = hazard;
    pc_write   = !hold;
    ifid_write = !hold;
    ctl_zero   = hold;
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hzd_pkg::*;
(
  input  logic [REG_IDX_W-1:0] src_a_idx,
  input  logic                 src_a_used,
  input  logic [REG_IDX_W-1:0] src_b_idx,
  input  logic                 src_b_used,
  input  logic [REG_IDX_W-1:0] exq_dst_idx,
  input  logic                 exq_dst_wen,
  input  logic [REG_IDX_W-1:0] memq_dst_idx,
  input  logic                 memq_dst_wen,
  output logic                 pc_write,
  output logic                 ifid_write,
  output logic                 ctl_zero
);
  src_fld_t   srcs  [NUM_SRC];
  prod_slot_t slots [NUM_SLOT];
  logic       hazard;

  always_comb begin
    srcs[0]  = '{idx: src_a_idx,    used: src_a_used};
    srcs[1]  = '{idx: src_b_idx,    used: src_b_used};
    slots[0] = '{dst: exq_dst_idx,  wen:  exq_dst_wen};
    slots[1] = '{dst: memq_dst_idx, wen:  memq_dst_wen};
  end

  hzd_detect u_detect (
    .srcs   (srcs),
    .slots  (slots),
    .hazard (hazard)
  );

  hzd_ctl u_ctl (
    .hazard     (hazard),
    .pc_write   (pc_write),
    .ifid_write (ifid_write),
    .ctl_zero   (ctl_zero)
  );

  always_comb begin
    // R1
    if (src_a_used && exq_dst_wen && exq_dst_idx != '0 && src_a_idx == exq_dst_idx)
      exq_stall_chk: assert (!pc_write) else $error("missed execute-stage dependency");
    // R2
    if (src_b_used && memq_dst_wen && memq_dst_idx != '0 && src_b_idx == memq_dst_idx)
      memq_stall_chk: assert (!pc_write) else $error("missed memory-stage dependency");
    // R4
    if (!exq_dst_wen && !memq_dst_wen)
      no_wen_chk: assert (pc_write) else $error("stall without any write enable");
    // R6
    outs_agree_chk: assert (ifid_write == pc_write && ctl_zero == !pc_write)
      else $error("stall outputs disagree");
  end
endmodule

// File: tb/tb_hazard_stall_unit.sv
module tb_hazard_stall_unit;
  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 5000;

  logic       clk = 1'b0;
  logic [4:0] src_a_idx, src_b_idx, exq_dst_idx, memq_dst_idx;
  logic       src_a_used, src_b_used, exq_dst_wen, memq_dst_wen;
  logic       pc_write, ifid_write, ctl_zero;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hazard_stall_unit dut (
    .src_a_idx(src_a_idx), .src_a_used(src_a_used),
    .src_b_idx(src_b_idx), .src_b_used(src_b_used),
    .exq_dst_idx(exq_dst_idx), .exq_dst_wen(exq_dst_wen),
    .memq_dst_idx(memq_dst_idx), .memq_dst_wen(memq_dst_wen),
    .pc_write(pc_write), .ifid_write(ifid_write), .ctl_zero(ctl_zero)
  );

  typedef struct packed {
    logic [4:0] sa; logic ua; logic [4:0] sb; logic ub;
    logic [4:0] de; logic we; logic [4:0] dm; logic wm;
    logic       stall;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd5,  1'b1, 5'd0,  1'b0, 5'd5,  1'b1, 5'd0,  1'b0, 1'b1, 4'd1}, // R1
    '{5'd0,  1'b0, 5'd7,  1'b1, 5'd0,  1'b0, 5'd7,  1'b1, 1'b1, 4'd2}, // R2
    '{5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 4'd3}, // R3
    '{5'd3,  1'b1, 5'd3,  1'b1, 5'd3,  1'b0, 5'd3,  1'b0, 1'b0, 4'd4}, // R4
    '{5'd4,  1'b0, 5'd4,  1'b0, 5'd4,  1'b1, 5'd4,  1'b1, 1'b0, 4'd5}, // R5
    '{5'd1,  1'b1, 5'd2,  1'b1, 5'd8,  1'b1, 5'd9,  1'b1, 1'b0, 4'd7}, // R7
    '{5'd0,  1'b0, 5'd6,  1'b1, 5'd6,  1'b1, 5'd0,  1'b0, 1'b1, 4'd9}, // R9
    '{5'd9,  1'b1, 5'd9,  1'b0, 5'd9,  1'b0, 5'd9,  1'b0, 1'b0, 4'd4}, // R4
    '{5'd12, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 5'd12, 1'b1, 1'b1, 4'd9}, // R9
    '{5'd31, 1'b1, 5'd30, 1'b1, 5'd29, 1'b1, 5'd31, 1'b1, 1'b1, 4'd2}  // R2
  };

  task automatic check_outs(input logic exp_stall, input int req);
    n_chk++;
    if (pc_write !== !exp_stall || ifid_write !== !exp_stall || ctl_zero !== exp_stall) begin
      n_fail++;
      $display("FAIL R%0d: pc_write=%b ifid_write=%b ctl_zero=%b expected %b %b %b",
               req, pc_write, ifid_write, ctl_zero, !exp_stall, !exp_stall, exp_stall);
    end
  endtask

  typedef struct packed {
    logic [4:0] rd; logic wen; logic [4:0] rs1; logic u1; logic [4:0] rs2; logic u2;
  } ins_t;

  // R8: pipeline model; counts stall cycles until every instruction leaves decode
  task automatic run_seq(input int gap, input logic [4:0] prd, input bit via_b,
                         input int exp, input string what);
    ins_t prog [6];
    int   n = gap + 2;
    int   id = 0;
    int   stalls = 0;
    int   guard = 0;
    logic [4:0] e_d = '0, m_d = '0;
    logic       e_w = 1'b0, m_w = 1'b0;
    prog[0] = '{prd, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0};
    for (int k = 1; k <= gap; k++) prog[k] = '{5'(20 + k), 1'b1, 5'd10, 1'b1, 5'd11, 1'b1};
    prog[gap+1] = via_b ? '{5'd25, 1'b1, 5'd13, 1'b1, prd, 1'b1}
                        : '{5'd25, 1'b1, prd, 1'b1, 5'd14, 1'b1};
    while (id < n && guard < 20) begin
      @(negedge clk);
      src_a_idx = prog[id].rs1; src_a_used = prog[id].u1;
      src_b_idx = prog[id].rs2; src_b_used = prog[id].u2;
      exq_dst_idx = e_d; exq_dst_wen = e_w;
      memq_dst_idx = m_d; memq_dst_wen = m_w;
      #1;
      if (!pc_write) stalls++;
      m_d = e_d; m_w = e_w;
      if (ctl_zero) begin
        e_d = '0; e_w = 1'b0;
      end else begin
        e_d = prog[id].rd; e_w = prog[id].wen;
      end
      if (ifid_write) id++;
      guard++;
    end
    n_chk++;
    if (stalls != exp) begin
      n_fail++;
      $display("FAIL R8 (%s): stall cycles=%0d expected %0d", what, stalls, exp);
    end
  endtask

  initial begin
    src_a_idx = '0; src_a_used = 1'b0; src_b_idx = '0; src_b_used = 1'b0;
    exq_dst_idx = '0; exq_dst_wen = 1'b0; memq_dst_idx = '0; memq_dst_wen = 1'b0;
    @(negedge clk);
    check_outs(1'b0, 7); // R7: idle inputs give no stall

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_a_idx = VECS[i].sa; src_a_used = VECS[i].ua;
      src_b_idx = VECS[i].sb; src_b_used = VECS[i].ub;
      exq_dst_idx = VECS[i].de; exq_dst_wen = VECS[i].we;
      memq_dst_idx = VECS[i].dm; memq_dst_wen = VECS[i].wm;
      #1;
      check_outs(VECS[i].stall, int'(VECS[i].req)); // R6 checked on every vector
    end

    // R3: x0 producer in the memory slot with matching used source
    @(negedge clk);
    src_a_idx = 5'd0; src_a_used = 1'b1; src_b_idx = 5'd0; src_b_used = 1'b1;
    exq_dst_idx = 5'd17; exq_dst_wen = 1'b1; memq_dst_idx = 5'd0; memq_dst_wen = 1'b1;
    #1;
    check_outs(1'b0, 3);

    run_seq(0, 5'd8,  1'b0, 2, "adjacent, first source");
    run_seq(1, 5'd8,  1'b0, 1, "one apart");
    run_seq(2, 5'd8,  1'b0, 0, "two apart");
    run_seq(0, 5'd19, 1'b1, 2, "adjacent, second source");
    run_seq(0, 5'd0,  1'b0, 0, "adjacent, x0 producer");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WD_LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule